// File: doc/BRIEF.md
# I2C Receive Data Register with Holding Stage

This block sits between an I2C byte shifter and a CPU register interface. Each byte the shifter completes goes into a two-entry queue. The front entry is the data register that the CPU sees. The back entry is a holding stage, so the shifter can keep receiving while the CPU has not yet read. A CPU read moves the queue forward. Any byte in the holding stage then becomes visible.

Each byte is tagged when it completes. In slave mode the tag marks the calling address sent by the master. In master mode, and for slave data bytes, the tag is clear. The tag travels with its byte, so the address-match output always describes the byte that is visible now. A buffer-full flag shows that an unread byte is visible. A receive flag is raised each time a byte enters the data register, and the CPU clears it by writing one. The interrupt request is this flag gated by an enable input. A byte that arrives while both entries are full is dropped and sets a sticky overrun flag.

Top module: `i2c_rx_holdreg`

## Requirements
- R1: A read strobe while `buf_full`=1 and the holding stage is empty clears `buf_full` on the next cycle. `rd_data` and `addr_match` keep their values. A read strobe while `buf_full`=0 changes no output.
- R2: A read strobe while both entries are full shows the held byte on `rd_data` on the next cycle, and `buf_full` stays 1.
- R3: Every time a byte enters the data register, `rx_flag` is 1 on the next cycle. This covers a byte arriving into an empty register and a byte advancing from the holding stage.
- R4: In slave mode (`mode_master`=0), a byte completed with `byte_is_addr`=1 appears with `addr_match`=1, and `rd_data` equals the calling address.
- R5: In slave mode, a byte completed with `byte_is_addr`=0 appears with `addr_match`=0.
- R6: In master mode (`mode_master`=1), every byte appears with `addr_match`=0, whatever the value of `byte_is_addr`.
- R7: `buf_full` is 1 whenever an unread byte is visible. A second byte that arrives before a read waits in the holding stage, and `rd_data` keeps the first byte.
- R8: Writing one on `rx_flag_clr` clears `rx_flag`. If a byte enters the data register in the same cycle, the new byte wins and `rx_flag` stays set. `irq` equals `rx_flag` AND `irq_en`.
- R9: A byte that completes while both entries are full, with no read in the same cycle, is dropped. `ovr_flag` is then set and stays set until `ovr_flag_clr` is written as one.
- R10: `addr_match` is latched with its byte. When a byte advances from the holding stage, `addr_match` takes that byte's own tag.
- R11: After reset, every output is 0.
- R12: A read and a completed byte can arrive in the same cycle. If the holding stage is full, the held byte becomes visible and the new byte is held. If the holding stage is empty, the new byte becomes visible directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Byte-complete strobe from the shifter |
| byte_data | input | DATA_W | Completed byte |
| byte_is_addr | input | 1 | Completed byte is a matched calling address |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| rd_strobe | input | 1 | CPU read of the data register |
| rx_flag_clr | input | 1 | Write-one-to-clear for the receive flag |
| ovr_flag_clr | input | 1 | Write-one-to-clear for the overrun flag |
| irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | DATA_W | Data register |
| addr_match | output | 1 | Visible byte is a calling address |
| buf_full | output | 1 | Unread byte visible |
| rx_flag | output | 1 | Receive flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result appears one clock edge after the strobe that causes it: `rd_data`, `addr_match`, `buf_full`, `rx_flag` and `ovr_flag`. `irq` is combinational from `rx_flag` and `irq_en`, so it follows a change of the enable in the same cycle. The bench applies each vector on a falling edge and holds it for exactly one rising edge. It compares all outputs just after that edge, before the next vector is applied. This places every comparison in the cycle where the expected result first becomes due.

// File: rtl/i2c_rxq_pkg.sv
package i2c_rxq_pkg;
    // index of each sticky status flag
    typedef enum int unsigned {
        FLG_RX  = 0,
        FLG_OVR = 1
    } flag_idx_e;
    localparam int unsigned FLG_COUNT = 2;
endpackage

// File: rtl/rxq_stage_ctrl.sv
module rxq_stage_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_tag,
    input  logic              pop,
    output logic              cur_vld,
    output logic [DATA_W-1:0] cur_data,
    output logic              cur_tag,
    output logic              hld_vld,
    output logic [DATA_W-1:0] hld_data,
    output logic              loaded,
    output logic              dropped
);
    typedef struct packed {
        logic              cur_vld;
        logic [DATA_W-1:0] cur_data;
        logic              cur_tag;
        logic              hld_vld;
        logic [DATA_W-1:0] hld_data;
        logic              hld_tag;
    } st_t;

    st_t  st_d, st_q;
    logic pop_eff;
    logic loaded_d, dropped_d;

    always_comb begin
        st_d      = st_q;
        loaded_d  = 1'b0;
        dropped_d = 1'b0;
        pop_eff   = pop && st_q.cur_vld;
        if (pop_eff && st_q.hld_vld) begin
            // advance the held byte, the new byte (if any) refills the back
            st_d.cur_data = st_q.hld_data;
            st_d.cur_tag  = st_q.hld_tag;
            st_d.cur_vld  = 1'b1;
            loaded_d      = 1'b1;
            st_d.hld_vld  = push;
            if (push) begin
                st_d.hld_data = push_data;
                st_d.hld_tag  = push_tag;
            end
        end else if (!st_q.cur_vld || pop_eff) begin
            // front is free after this cycle
            if (push) begin
                st_d.cur_data = push_data;
                st_d.cur_tag  = push_tag;
                st_d.cur_vld  = 1'b1;
                loaded_d      = 1'b1;
            end else begin
                st_d.cur_vld  = 1'b0;
            end
        end else if (push) begin
            if (!st_q.hld_vld) begin
                st_d.hld_data = push_data;
                st_d.hld_tag  = push_tag;
                st_d.hld_vld  = 1'b1;
            end else begin
                dropped_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_vld  = st_q.cur_vld;
    assign cur_data = st_q.cur_data;
    assign cur_tag  = st_q.cur_tag;
    assign hld_vld  = st_q.hld_vld;
    assign hld_data = st_q.hld_data;
    assign loaded   = loaded_d;
    assign dropped  = dropped_d;
endmodule

// File: rtl/rxq_sticky_flags.sv
module rxq_sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_d, f_q;
        // a new event in the same cycle as the clear keeps the flag set
        always_comb begin
            f_d = f_q;
            if (clr[i]) f_d = 1'b0;
            if (set[i]) f_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= f_d;
        end
        assign flag[i] = f_q;
    end
endmodule

// File: rtl/i2c_rx_holdreg.sv
module i2c_rx_holdreg
    import i2c_rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_is_addr,
    input  logic              mode_master,
    input  logic              rd_strobe,
    input  logic              rx_flag_clr,
    input  logic              ovr_flag_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              addr_match,
    output logic              buf_full,
    output logic              rx_flag,
    output logic              ovr_flag,
    output logic              irq
);
    logic              tag_in;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    logic              loaded, dropped;
    logic [FLG_COUNT-1:0] flg_set, flg_clr, flg_q;

    // calling-address tag exists only in slave mode
    assign tag_in = byte_is_addr && !mode_master;

    rxq_stage_ctrl #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (byte_vld),
        .push_data (byte_data),
        .push_tag  (tag_in),
        .pop       (rd_strobe),
        .cur_vld   (buf_full),
        .cur_data  (rd_data),
        .cur_tag   (addr_match),
        .hld_vld   (hold_vld),
        .hld_data  (hold_data),
        .loaded    (loaded),
        .dropped   (dropped)
    );

    always_comb begin
        flg_set          = '0;
        flg_clr          = '0;
        flg_set[FLG_RX]  = loaded;
        flg_clr[FLG_RX]  = rx_flag_clr;
        flg_set[FLG_OVR] = dropped;
        flg_clr[FLG_OVR] = ovr_flag_clr;
    end

    rxq_sticky_flags #(.N(FLG_COUNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flg_set),
        .clr   (flg_clr),
        .flag  (flg_q)
    );

    assign rx_flag  = flg_q[FLG_RX];
    assign ovr_flag = flg_q[FLG_OVR];
    assign irq      = rx_flag && irq_en;
endmodule

// File: rtl/i2c_rxq_chk.sv
module i2c_rxq_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [DATA_W-1:0] byte_data,
    input logic              byte_is_addr,
    input logic              mode_master,
    input logic              rd_strobe,
    input logic              rx_flag_clr,
    input logic [DATA_W-1:0] rd_data,
    input logic              addr_match,
    input logic              buf_full,
    input logic              rx_flag,
    input logic              ovr_flag,
    input logic              hold_vld,
    input logic [DATA_W-1:0] hold_data
);
    p_read_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && buf_full && !hold_vld && !byte_vld) |=> !buf_full);

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && buf_full && hold_vld) |=> (buf_full && rd_data == $past(hold_data)));

    p_entry_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !buf_full) |=> (rx_flag && buf_full && rd_data == $past(byte_data)));

    p_slave_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !buf_full && byte_is_addr && !mode_master) |=> addr_match);

    p_master_notag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !buf_full && mode_master) |=> !addr_match);

    p_flag_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rx_flag_clr) |=> rx_flag);

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && buf_full && hold_vld && !rd_strobe) |=> ovr_flag);

    p_hold_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && buf_full && !hold_vld && !rd_strobe) |=> $stable(rd_data));
endmodule

bind i2c_rx_holdreg i2c_rxq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_data    (byte_data),
    .byte_is_addr (byte_is_addr),
    .mode_master  (mode_master),
    .rd_strobe    (rd_strobe),
    .rx_flag_clr  (rx_flag_clr),
    .rd_data      (rd_data),
    .addr_match   (addr_match),
    .buf_full     (buf_full),
    .rx_flag      (rx_flag),
    .ovr_flag     (ovr_flag),
    .hold_vld     (hold_vld),
    .hold_data    (hold_data)
);

// File: tb/i2c_rx_holdreg_bench.sv
module i2c_rx_holdreg_bench;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          byte_is_addr = 1'b0;
    logic          mode_master = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          rx_flag_clr = 1'b0;
    logic          ovr_flag_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          addr_match, buf_full, rx_flag, ovr_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    i2c_rx_holdreg #(.DATA_W(DW)) u_i2c_rx_holdreg (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_is_addr(byte_is_addr), .mode_master(mode_master), .rd_strobe(rd_strobe),
        .rx_flag_clr(rx_flag_clr), .ovr_flag_clr(ovr_flag_clr), .irq_en(irq_en),
        .rd_data(rd_data), .addr_match(addr_match), .buf_full(buf_full),
        .rx_flag(rx_flag), .ovr_flag(ovr_flag), .irq(irq)
    );

    typedef struct packed {
        logic       vld;
        logic [7:0] dat;
        logic       adr;
        logic       mst;
        logic       rd;
        logic       fclr;
        logic       oclr;
        logic       ien;
        logic       e_full;
        logic [7:0] e_dat;
        logic       e_mat;
        logic       e_rx;
        logic       e_ovr;
        logic       e_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        //  vld  dat    adr  mst  rd   fclr oclr ien  full edat   mat  rx   ovr  irq  req
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'd11}, // R11 idle
        '{1'b1,8'hA4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'hA4,1'b1,1'b1,1'b0,1'b1,4'd4},  // R4 address
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'hA4,1'b1,1'b0,1'b0,1'b0,4'd8},  // R8 w1c
        '{1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'hA4,1'b1,1'b0,1'b0,1'b0,4'd7},  // R7 waits
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h11,1'b0,1'b1,1'b0,1'b1,4'd2},  // R2 advance, R10 tag
        '{1'b1,8'h22,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,1'b0,1'b1,1'b0,1'b1,4'd7},  // R7
        '{1'b1,8'h33,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,1'b0,1'b1,1'b1,1'b1,4'd9},  // R9 drop
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h22,1'b0,1'b1,1'b1,1'b1,4'd9},  // R9 33 lost, sticky
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h22,1'b0,1'b1,1'b1,1'b1,4'd1},  // R1 empties
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h22,1'b0,1'b1,1'b1,1'b1,4'd1},  // R1 read when empty
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h22,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 clear
        '{1'b1,8'h5A,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b0,1'b1,1'b0,1'b0,4'd6},  // R6 master, R8 gated
        '{1'b1,8'h66,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h66,1'b0,1'b1,1'b0,1'b0,4'd12}, // R12 hold empty
        '{1'b1,8'h77,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h66,1'b0,1'b1,1'b0,1'b0,4'd7},  // R7
        '{1'b1,8'h88,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h77,1'b1,1'b1,1'b0,1'b0,4'd12}, // R12 hold full, R10
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h88,1'b0,1'b1,1'b0,1'b0,4'd5},  // R5 data tag
        '{1'b1,8'h99,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,8'h99,1'b0,1'b1,1'b0,1'b0,4'd3},  // R3 / R8 set wins
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h99,1'b0,1'b1,1'b0,1'b1,4'd1}   // R1
    };

    task automatic check_all(input string tag, input logic e_full, input logic [7:0] e_dat,
                             input logic e_mat, input logic e_rx, input logic e_ovr, input logic e_irq);
        n_cmp++;
        if (buf_full !== e_full || rd_data !== e_dat || addr_match !== e_mat ||
            rx_flag !== e_rx || ovr_flag !== e_ovr || irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s: got full=%b data=%h match=%b rx=%b ovr=%b irq=%b exp full=%b data=%h match=%b rx=%b ovr=%b irq=%b",
                     tag, buf_full, rd_data, addr_match, rx_flag, ovr_flag, irq,
                     e_full, e_dat, e_mat, e_rx, e_ovr, e_irq);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        byte_vld = v.vld; byte_data = v.dat; byte_is_addr = v.adr; mode_master = v.mst;
        rd_strobe = v.rd; rx_flag_clr = v.fclr; ovr_flag_clr = v.oclr; irq_en = v.ien;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t idle_vec(input logic ien);
        vec_t v = '0;
        v.ien = ien;
        return v;
    endfunction

    initial begin
        fork
            begin
                repeat (2000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got timeout exp completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        #1;
        check_all("R11 reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check_all($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].e_full, TBL[i].e_dat,
                      TBL[i].e_mat, TBL[i].e_rx, TBL[i].e_ovr, TBL[i].e_irq);
        end

        // R8: irq follows the enable in the same cycle
        @(negedge clk);
        irq_en = 1'b1; rd_strobe = 1'b0;
        #1;
        check_all("R8 enable", 1'b0, 8'h99, 1'b0, 1'b1, 1'b0, 1'b1);

        // R9: overrun wins over a same-cycle clear
        begin
            vec_t v;
            v = idle_vec(1'b1); v.vld = 1'b1; v.dat = 8'hC1; apply(v);
            v = idle_vec(1'b1); v.vld = 1'b1; v.dat = 8'hC2; apply(v);
            v = idle_vec(1'b1); v.vld = 1'b1; v.dat = 8'hC3; v.oclr = 1'b1; apply(v);
            check_all("R9 set wins", 1'b1, 8'hC1, 1'b0, 1'b1, 1'b1, 1'b1);
        end

        // R11: reset while full clears everything
        @(negedge clk);
        rst_n = 1'b0;
        byte_vld = 1'b0; ovr_flag_clr = 1'b0;
        #1;
        check_all("R11 mid reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule